// File: doc/BRIEF.md
# Dual-Bank Long-Word Move Unit

This block carries out a 48-bit long-word transfer between a DSP register file and two parallel 24-bit data memories, called the X bank and the Y bank. One address selects the same location in both banks, so a single access moves both halves of the long word. A 3-bit pair selector chooses the register side of the transfer. Some codes treat the two halves as one 48-bit signed double-precision value held in an accumulator. Other codes treat them as two independent 24-bit signed values, such as the real and imaginary parts of a complex sample.

Each instruction arrives with the destination of the arithmetic operation that issues alongside it. The unit rejects any load whose destination overlaps that accumulator. It also rejects pair codes used outside a long move, reserved codes and reserved ALU destination values. A rejected instruction writes nothing and raises a one-cycle illegal flag instead of the done strobe.

The unit accepts one instruction per clock. The memories are synchronous with one cycle of read latency. Every instruction ends exactly two cycles after it is accepted, either with the done strobe or with the illegal flag.

Top module: `lwmove_unit`

## Requirements
- R1: An accepted instruction places one address on both banks' address outputs in the next cycle. That address is `in_ea` when `in_abs_mode` is 0, and `in_sabs` zero-extended when `in_abs_mode` is 1.
- R2: A legal store (`in_store`=1) asserts `xm_we` and `ym_we` together one cycle after acceptance. The first (upper) half goes to the X bank and the second (lower) half goes to the Y bank.
- R3: Pair codes 0 (A1:A0) and 1 (B1:B0) move accumulator bits 47:0 as one 48-bit value. A store copies these bits unmodified. A load writes the 48 bits and fills accumulator bits 55:48 with copies of bit 47.
- R4: Pair codes 2 (X1:X0) and 3 (Y1:Y0) move the 48-bit input register. Bits 47:24 pair with the X bank and bits 23:0 pair with the Y bank.
- R5: A store with code 4 (AB: A to X, B to Y) or code 5 (BA: B to X, A to Y) reads each accumulator as a 24-bit value. When accumulator bits 55:47 are not all equal, the value saturates to 0x7FFFFF if bit 55 is 0 and to 0x800000 if bit 55 is 1, and `limit` is asserted with `done`.
- R6: A load with code 4 or code 5 writes each 24-bit word into accumulator bits 47:24, copies its sign into bits 55:48 and clears bits 23:0. Code 4 takes A from X and B from Y; code 5 takes B from X and A from Y.
- R7: A legal load asserts `xm_re` and `ym_re` one cycle after acceptance. One cycle later it asserts the matching register-file write enables, with data formed from the returned memory words, together with `done`.
- R8: `in_alu_dst` values are 0 (none), 1 (accumulator A), 2 (accumulator B) and 3 (reserved). A load is illegal when the ALU writes A and the code is 0, 4 or 5, or when the ALU writes B and the code is 1, 4 or 5.
- R9: A store is never illegal because of `in_alu_dst` 1 or 2, so an ALU source or destination register may also be the move source.
- R10: An instruction is illegal when `in_long` is 0, when `in_sel` is 6 or 7, or when `in_alu_dst` is 3.
- R11: An illegal instruction raises `illegal` for exactly one cycle, two cycles after acceptance. It causes no memory write or read, no register-file write and no `done`.
- R12: A legal store pulses `done` two cycles after acceptance, one cycle after its memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_long | input | 1 | Instruction is a long move |
| in_store | input | 1 | 1 = registers to memory, 0 = memory to registers |
| in_sel | input | 3 | Pair selector code |
| in_alu_dst | input | 2 | Destination of the concurrent ALU operation |
| in_abs_mode | input | 1 | Use short absolute address |
| in_ea | input | AW | Effective address |
| in_sabs | input | SAW | Short absolute address |
| rf_a | input | EW+2*HW | Accumulator A read value |
| rf_b | input | EW+2*HW | Accumulator B read value |
| rf_x | input | 2*HW | Input register X read value |
| rf_y | input | 2*HW | Input register Y read value |
| xm_addr | output | AW | X bank address |
| xm_we | output | 1 | X bank write enable |
| xm_re | output | 1 | X bank read enable |
| xm_wdata | output | HW | X bank write data |
| xm_rdata | input | HW | X bank read data, one cycle after xm_re |
| ym_addr | output | AW | Y bank address |
| ym_we | output | 1 | Y bank write enable |
| ym_re | output | 1 | Y bank read enable |
| ym_wdata | output | HW | Y bank write data |
| ym_rdata | input | HW | Y bank read data, one cycle after ym_re |
| rf_we_a | output | 1 | Write accumulator A |
| rf_we_b | output | 1 | Write accumulator B |
| rf_we_x | output | 1 | Write register X |
| rf_we_y | output | 1 | Write register Y |
| rf_wd_a | output | EW+2*HW | Accumulator A write data |
| rf_wd_b | output | EW+2*HW | Accumulator B write data |
| rf_wd_x | output | 2*HW | Register X write data |
| rf_wd_y | output | 2*HW | Register Y write data |
| done | output | 1 | Legal instruction completed |
| illegal | output | 1 | Instruction rejected |
| limit | output | 1 | A store saturated a 24-bit half |

## Verification
The unit is pipelined, so one instruction's register-file write can fall in the same cycle as the next instruction's memory write. The bench provokes this by issuing a load from an address on one clock and a store to that same address on the next. In the shared cycle it checks that the load delivers the old memory contents while the store presents its new words on both banks, and that `done` pulses in two consecutive cycles. A later load from that address must return the stored words. This shows that the read was not disturbed by the write that overlapped it.

// File: rtl/lwmove_pkg.sv
package lwmove_pkg;
  typedef logic [2:0] pair_t;
  localparam pair_t PR_A10 = 3'd0;
  localparam pair_t PR_B10 = 3'd1;
  localparam pair_t PR_X   = 3'd2;
  localparam pair_t PR_Y   = 3'd3;
  localparam pair_t PR_AB  = 3'd4;
  localparam pair_t PR_BA  = 3'd5;

  typedef logic [1:0] alu_t;
  localparam alu_t ALU_NONE = 2'd0;
  localparam alu_t ALU_A    = 2'd1;
  localparam alu_t ALU_B    = 2'd2;
  localparam alu_t ALU_RSV  = 2'd3;
endpackage

// File: rtl/lwmove_decode.sv
module lwmove_decode
  import lwmove_pkg::*;
#(
  parameter int AW  = 16,
  parameter int SAW = 6
) (
  input  logic           valid,
  input  logic           is_long,
  input  logic           store,
  input  pair_t          sel,
  input  alu_t           alu_dst,
  input  logic           abs_mode,
  input  logic [AW-1:0]  ea,
  input  logic [SAW-1:0] sabs,
  output logic           go,
  output logic           bad,
  output logic [AW-1:0]  addr
);
  logic code_ok, hits_a, hits_b, clash;

  always_comb begin
    code_ok = (sel <= PR_BA);
    hits_a  = (sel == PR_A10) || (sel == PR_AB) || (sel == PR_BA);
    hits_b  = (sel == PR_B10) || (sel == PR_AB) || (sel == PR_BA);
    // only a load has a destination that can collide with the ALU result
    clash   = !store && (((alu_dst == ALU_A) && hits_a) ||
                         ((alu_dst == ALU_B) && hits_b));
    bad     = valid && (!is_long || !code_ok || (alu_dst == ALU_RSV) || clash);
    go      = valid && !bad;
    addr    = abs_mode ? {{(AW-SAW){1'b0}}, sabs} : ea;
  end
endmodule

// File: rtl/lwmove_sat.sv
module lwmove_sat #(
  parameter int HW = 24,
  parameter int EW = 8,
  localparam int ACC_W = EW + 2*HW
) (
  input  logic [ACC_W-1:0] acc,
  output logic [HW-1:0]    q,
  output logic             ovf
);
  logic [EW:0] head;

  always_comb begin
    head = acc[ACC_W-1 -: EW+1];
    ovf  = !((&head) || !(|head));
    if (!ovf)
      q = acc[2*HW-1 -: HW];
    else if (acc[ACC_W-1])
      q = {1'b1, {(HW-1){1'b0}}};
    else
      q = {1'b0, {(HW-1){1'b1}}};
  end
endmodule

// File: rtl/lwmove_pack.sv
module lwmove_pack
  import lwmove_pkg::*;
#(
  parameter int HW = 24,
  parameter int EW = 8,
  localparam int ACC_W = EW + 2*HW,
  localparam int LW    = 2*HW
) (
  input  pair_t            sel,
  input  logic [ACC_W-1:0] a,
  input  logic [ACC_W-1:0] b,
  input  logic [LW-1:0]    x,
  input  logic [LW-1:0]    y,
  output logic [HW-1:0]    xw,
  output logic [HW-1:0]    yw,
  output logic             lim
);
  logic [ACC_W-1:0] acc_in [2];
  logic [HW-1:0]    sat_q  [2];
  logic [1:0]       sat_o;

  assign acc_in[0] = a;
  assign acc_in[1] = b;

  for (genvar g = 0; g < 2; g++) begin : g_sat
    lwmove_sat #(.HW(HW), .EW(EW)) u_sat (
      .acc (acc_in[g]),
      .q   (sat_q[g]),
      .ovf (sat_o[g])
    );
  end

  always_comb begin
    xw  = '0;
    yw  = '0;
    lim = 1'b0;
    case (sel)
      PR_A10: begin xw = a[LW-1:HW]; yw = a[HW-1:0]; end
      PR_B10: begin xw = b[LW-1:HW]; yw = b[HW-1:0]; end
      PR_X:   begin xw = x[LW-1:HW]; yw = x[HW-1:0]; end
      PR_Y:   begin xw = y[LW-1:HW]; yw = y[HW-1:0]; end
      PR_AB:  begin xw = sat_q[0]; yw = sat_q[1]; lim = |sat_o; end
      PR_BA:  begin xw = sat_q[1]; yw = sat_q[0]; lim = |sat_o; end
      default: ;
    endcase
  end
endmodule

// File: rtl/lwmove_unpack.sv
module lwmove_unpack
  import lwmove_pkg::*;
#(
  parameter int HW = 24,
  parameter int EW = 8,
  localparam int ACC_W = EW + 2*HW,
  localparam int LW    = 2*HW
) (
  input  logic             en,
  input  pair_t            sel,
  input  logic [HW-1:0]    xd,
  input  logic [HW-1:0]    yd,
  output logic             we_a,
  output logic             we_b,
  output logic             we_x,
  output logic             we_y,
  output logic [ACC_W-1:0] wa,
  output logic [ACC_W-1:0] wb,
  output logic [LW-1:0]    wx,
  output logic [LW-1:0]    wy
);
  logic [ACC_W-1:0] wide, from_x, from_y;

  always_comb begin
    wide   = {{EW{xd[HW-1]}}, xd, yd};
    from_x = {{EW{xd[HW-1]}}, xd, {HW{1'b0}}};
    from_y = {{EW{yd[HW-1]}}, yd, {HW{1'b0}}};
    wx     = {xd, yd};
    wy     = {xd, yd};
    we_a   = en && ((sel == PR_A10) || (sel == PR_AB) || (sel == PR_BA));
    we_b   = en && ((sel == PR_B10) || (sel == PR_AB) || (sel == PR_BA));
    we_x   = en && (sel == PR_X);
    we_y   = en && (sel == PR_Y);
    case (sel)
      PR_AB:   begin wa = from_x; wb = from_y; end
      PR_BA:   begin wa = from_y; wb = from_x; end
      default: begin wa = wide;   wb = wide;   end
    endcase
  end
endmodule

// File: rtl/lwmove_unit.sv
module lwmove_unit
  import lwmove_pkg::*;
#(
  parameter int AW  = 16,
  parameter int SAW = 6,
  parameter int HW  = 24,
  parameter int EW  = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 in_long,
  input  logic                 in_store,
  input  logic [2:0]           in_sel,
  input  logic [1:0]           in_alu_dst,
  input  logic                 in_abs_mode,
  input  logic [AW-1:0]        in_ea,
  input  logic [SAW-1:0]       in_sabs,
  input  logic [EW+2*HW-1:0]   rf_a,
  input  logic [EW+2*HW-1:0]   rf_b,
  input  logic [2*HW-1:0]      rf_x,
  input  logic [2*HW-1:0]      rf_y,
  output logic [AW-1:0]        xm_addr,
  output logic                 xm_we,
  output logic                 xm_re,
  output logic [HW-1:0]        xm_wdata,
  input  logic [HW-1:0]        xm_rdata,
  output logic [AW-1:0]        ym_addr,
  output logic                 ym_we,
  output logic                 ym_re,
  output logic [HW-1:0]        ym_wdata,
  input  logic [HW-1:0]        ym_rdata,
  output logic                 rf_we_a,
  output logic                 rf_we_b,
  output logic                 rf_we_x,
  output logic                 rf_we_y,
  output logic [EW+2*HW-1:0]   rf_wd_a,
  output logic [EW+2*HW-1:0]   rf_wd_b,
  output logic [2*HW-1:0]      rf_wd_x,
  output logic [2*HW-1:0]      rf_wd_y,
  output logic                 done,
  output logic                 illegal,
  output logic                 limit
);
  localparam int ACC_W = EW + 2*HW;

  logic          d_go, d_bad;
  logic [AW-1:0] d_addr;
  logic [HW-1:0] p_xw, p_yw;
  logic          p_lim;

  // stage 1: memory access cycle
  logic  s1_go, s1_bad, s1_lim, s1_load;
  pair_t s1_sel;
  // stage 2: register write / completion cycle
  logic  s2_load;
  pair_t s2_sel;

  lwmove_decode #(.AW(AW), .SAW(SAW)) u_dec (
    .valid    (in_valid),
    .is_long  (in_long),
    .store    (in_store),
    .sel      (in_sel),
    .alu_dst  (in_alu_dst),
    .abs_mode (in_abs_mode),
    .ea       (in_ea),
    .sabs     (in_sabs),
    .go       (d_go),
    .bad      (d_bad),
    .addr     (d_addr)
  );

  lwmove_pack #(.HW(HW), .EW(EW)) u_pack (
    .sel (in_sel),
    .a   (rf_a),
    .b   (rf_b),
    .x   (rf_x),
    .y   (rf_y),
    .xw  (p_xw),
    .yw  (p_yw),
    .lim (p_lim)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      xm_addr  <= '0;
      ym_addr  <= '0;
      xm_we    <= 1'b0;
      ym_we    <= 1'b0;
      xm_re    <= 1'b0;
      ym_re    <= 1'b0;
      xm_wdata <= '0;
      ym_wdata <= '0;
      s1_go    <= 1'b0;
      s1_bad   <= 1'b0;
      s1_lim   <= 1'b0;
      s1_load  <= 1'b0;
      s1_sel   <= PR_A10;
    end else begin
      if (d_go) begin
        xm_addr <= d_addr;
        ym_addr <= d_addr;
      end
      xm_we    <= d_go && in_store;
      ym_we    <= d_go && in_store;
      xm_re    <= d_go && !in_store;
      ym_re    <= d_go && !in_store;
      xm_wdata <= p_xw;
      ym_wdata <= p_yw;
      s1_go    <= d_go;
      s1_bad   <= d_bad;
      s1_lim   <= d_go && in_store && p_lim;
      s1_load  <= d_go && !in_store;
      s1_sel   <= in_sel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done    <= 1'b0;
      illegal <= 1'b0;
      limit   <= 1'b0;
      s2_load <= 1'b0;
      s2_sel  <= PR_A10;
    end else begin
      done    <= s1_go;
      illegal <= s1_bad;
      limit   <= s1_lim;
      s2_load <= s1_load;
      s2_sel  <= s1_sel;
    end
  end

  lwmove_unpack #(.HW(HW), .EW(EW)) u_unpack (
    .en   (s2_load),
    .sel  (s2_sel),
    .xd   (xm_rdata),
    .yd   (ym_rdata),
    .we_a (rf_we_a),
    .we_b (rf_we_b),
    .we_x (rf_we_x),
    .we_y (rf_we_y),
    .wa   (rf_wd_a),
    .wb   (rf_wd_b),
    .wx   (rf_wd_x),
    .wy   (rf_wd_y)
  );
endmodule

// File: rtl/lwmove_chk.sv
module lwmove_chk
  import lwmove_pkg::*;
#(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_long,
  input logic          in_store,
  input logic [2:0]    in_sel,
  input logic [1:0]    in_alu_dst,
  input logic [AW-1:0] xm_addr,
  input logic [AW-1:0] ym_addr,
  input logic          xm_we,
  input logic          ym_we,
  input logic          xm_re,
  input logic          rf_we_a,
  input logic          rf_we_b,
  input logic          rf_we_x,
  input logic          rf_we_y,
  input logic          done,
  input logic          illegal,
  input logic          limit
);
  logic any_rf;
  assign any_rf = rf_we_a || rf_we_b || rf_we_x || rf_we_y;

  a_r1_one_address: assert property (@(posedge clk) disable iff (rst)
    (xm_we || xm_re) |-> (xm_addr == ym_addr));

  a_r12_store_done: assert property (@(posedge clk) disable iff (rst)
    xm_we |=> done);

  a_r7_read_then_write: assert property (@(posedge clk) disable iff (rst)
    xm_re |=> (any_rf && done));

  a_r5_limit_on_store: assert property (@(posedge clk) disable iff (rst)
    limit |-> (done && $past(xm_we)));

  a_r11_quiet_memory: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!$past(xm_we) && !$past(ym_we) && !$past(xm_re)));

  a_r11_quiet_regs: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!any_rf && !done));

  a_r8_pair_clash: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_long && !in_store && in_alu_dst == ALU_A && in_sel == PR_AB)
      |=> ##1 illegal);
endmodule

bind lwmove_unit lwmove_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_long    (in_long),
  .in_store   (in_store),
  .in_sel     (in_sel),
  .in_alu_dst (in_alu_dst),
  .xm_addr    (xm_addr),
  .ym_addr    (ym_addr),
  .xm_we      (xm_we),
  .ym_we      (ym_we),
  .xm_re      (xm_re),
  .rf_we_a    (rf_we_a),
  .rf_we_b    (rf_we_b),
  .rf_we_x    (rf_we_x),
  .rf_we_y    (rf_we_y),
  .done       (done),
  .illegal    (illegal),
  .limit      (limit)
);

// File: tb/sim_lwmove_unit.sv
`timescale 1ns/1ps
module sim_lwmove_unit;
  import lwmove_pkg::*;

  localparam int AW = 16, SAW = 6, HW = 24, EW = 8;
  localparam int ACC_W = EW + 2*HW, LW = 2*HW;

  typedef struct packed {
    logic [2:0]       sel;
    logic [1:0]       alu;
    logic [ACC_W-1:0] a;
    logic [ACC_W-1:0] b;
    logic [LW-1:0]    x;
    logic [LW-1:0]    y;
    logic [HW-1:0]    ex;
    logic [HW-1:0]    ey;
    logic             el;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    // R3 store A1:A0, no saturation on the pair path
    '{3'd0, 2'd0, 56'h00_123456_789ABC, 56'h0, 48'h0, 48'h0, 24'h123456, 24'h789ABC, 1'b0},
    // R3 store B1:B0
    '{3'd1, 2'd0, 56'h0, 56'hFF_FEDCBA_987654, 48'h0, 48'h0, 24'hFEDCBA, 24'h987654, 1'b0},
    // R4 store X
    '{3'd2, 2'd0, 56'h0, 56'h0, 48'hAAAAAA_555555, 48'h0, 24'hAAAAAA, 24'h555555, 1'b0},
    // R4 store Y
    '{3'd3, 2'd0, 56'h0, 56'h0, 48'h0, 48'h010203_040506, 24'h010203, 24'h040506, 1'b0},
    // R5 AB, A saturates positive, B in range at most negative
    '{3'd4, 2'd0, 56'h01_000000_000000, 56'hFF_800000_000001, 48'h0, 48'h0, 24'h7FFFFF, 24'h800000, 1'b1},
    // R5 BA, B saturates negative
    '{3'd5, 2'd0, 56'h00_400000_000000, 56'hFE_000000_000000, 48'h0, 48'h0, 24'h800000, 24'h400000, 1'b1},
    // R5 AB both in range
    '{3'd4, 2'd0, 56'hFF_FFFFFF_000000, 56'h00_000001_FFFFFF, 48'h0, 48'h0, 24'hFFFFFF, 24'h000001, 1'b0},
    // R9 store A1:A0 while the ALU writes A
    '{3'd0, 2'd1, 56'h7F_0F0F0F_F0F0F0, 56'h0, 48'h0, 48'h0, 24'h0F0F0F, 24'hF0F0F0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic             in_valid = 0, in_long = 0, in_store = 0, in_abs_mode = 0;
  logic [2:0]       in_sel = 0;
  logic [1:0]       in_alu_dst = 0;
  logic [AW-1:0]    in_ea = 0;
  logic [SAW-1:0]   in_sabs = 0;
  logic [ACC_W-1:0] rf_a = 0, rf_b = 0;
  logic [LW-1:0]    rf_x = 0, rf_y = 0;
  logic [AW-1:0]    xm_addr, ym_addr;
  logic             xm_we, ym_we, xm_re, ym_re;
  logic [HW-1:0]    xm_wdata, ym_wdata;
  logic [HW-1:0]    xm_rdata = 0, ym_rdata = 0;
  logic             rf_we_a, rf_we_b, rf_we_x, rf_we_y;
  logic [ACC_W-1:0] rf_wd_a, rf_wd_b;
  logic [LW-1:0]    rf_wd_x, rf_wd_y;
  logic             done, illegal, limit;

  lwmove_unit #(.AW(AW), .SAW(SAW), .HW(HW), .EW(EW)) u0 (.*);

  // behavioural banks with one cycle of read latency
  logic [HW-1:0] xmem [256];
  logic [HW-1:0] ymem [256];
  logic          pl_we = 0;
  logic [7:0]    pl_addr = 0;
  logic [HW-1:0] pl_x = 0, pl_y = 0;

  always @(posedge clk) begin
    if (pl_we) begin
      xmem[pl_addr] <= pl_x;
      ymem[pl_addr] <= pl_y;
    end
    if (xm_we) xmem[xm_addr[7:0]] <= xm_wdata;
    if (ym_we) ymem[ym_addr[7:0]] <= ym_wdata;
    if (xm_re) xm_rdata <= xmem[xm_addr[7:0]];
    if (ym_re) ym_rdata <= ymem[ym_addr[7:0]];
  end

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  // observations one, two and three cycles after acceptance
  logic          o1_xwe, o1_ywe, o1_re, o1_rfwe;
  logic [AW-1:0] o1_ax, o1_ay;
  logic [HW-1:0] o1_xd, o1_yd;
  logic          o2_done, o2_ill, o2_lim, o3_ill;
  logic [3:0]    o2_we;
  logic [ACC_W-1:0] o2_wa, o2_wb;
  logic [LW-1:0]    o2_wx, o2_wy;

  task automatic drive(input logic st, input logic lg, input logic [2:0] sel,
                       input logic [1:0] alu, input logic absm,
                       input logic [AW-1:0] ea, input logic [SAW-1:0] sa);
    in_valid = 1; in_store = st; in_long = lg; in_sel = sel;
    in_alu_dst = alu; in_abs_mode = absm; in_ea = ea; in_sabs = sa;
  endtask

  task automatic run_op(input logic st, input logic lg, input logic [2:0] sel,
                        input logic [1:0] alu, input logic absm,
                        input logic [AW-1:0] ea, input logic [SAW-1:0] sa);
    @(negedge clk);
    drive(st, lg, sel, alu, absm, ea, sa);
    @(negedge clk);
    in_valid = 0;
    o1_xwe = xm_we; o1_ywe = ym_we; o1_re = xm_re | ym_re;
    o1_rfwe = rf_we_a | rf_we_b | rf_we_x | rf_we_y;
    o1_ax = xm_addr; o1_ay = ym_addr; o1_xd = xm_wdata; o1_yd = ym_wdata;
    @(negedge clk);
    o2_done = done; o2_ill = illegal; o2_lim = limit;
    o2_we = {rf_we_a, rf_we_b, rf_we_x, rf_we_y};
    o2_wa = rf_wd_a; o2_wb = rf_wd_b; o2_wx = rf_wd_x; o2_wy = rf_wd_y;
    @(negedge clk);
    o3_ill = illegal;
  endtask

  task automatic preload(input logic [7:0] ad, input logic [HW-1:0] xv, input logic [HW-1:0] yv);
    @(negedge clk);
    pl_we = 1; pl_addr = ad; pl_x = xv; pl_y = yv;
    @(negedge clk);
    pl_we = 0;
  endtask

  task automatic expect_reject(input string rq);
    chk({rq, " no memory access"}, {o1_xwe, o1_ywe, o1_re}, 3'b000);
    chk({rq, " illegal not done"}, {o2_done, o2_ill}, 2'b01);
    chk({rq, " no register write"}, {o2_we, o2_lim}, 5'b0);
    chk("R11 illegal lasts one cycle", o3_ill, 1'b0);
  endtask

  task automatic expect_load(input string rq, input logic [3:0] we);
    chk({rq, " read enable"}, {o1_re, o1_xwe, o1_rfwe}, 3'b100);
    chk({rq, " write enables"}, o2_we, we);
    chk({rq, " done"}, {o2_done, o2_ill}, 2'b10);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("reset outputs", {xm_we, ym_we, xm_re, ym_re, done, illegal, limit,
                          rf_we_a, rf_we_b, rf_we_x, rf_we_y}, 11'b0);
    rst = 0;

    // store table: R1, R2, R12 on every line
    for (int i = 0; i < NV; i++) begin
      rf_a = VEC[i].a; rf_b = VEC[i].b; rf_x = VEC[i].x; rf_y = VEC[i].y;
      run_op(1, 1, VEC[i].sel, VEC[i].alu, 0, AW'(16'h0100 + i), '0);
      chk("R2 both banks write", {o1_xwe, o1_ywe, o1_re}, 3'b110);
      chk("R2 first half to X", o1_xd, VEC[i].ex);
      chk("R2 second half to Y", o1_yd, VEC[i].ey);
      chk("R1 same address", {o1_ax, o1_ay}, {2{AW'(16'h0100 + i)}});
      chk("R12 store done", {o2_done, o2_ill, o2_we}, 6'b100000);
      chk("R5 limit flag", o2_lim, VEC[i].el);
    end

    // R1 short absolute address overrides the effective address
    rf_x = 48'h111111_222222;
    run_op(1, 1, PR_X, ALU_NONE, 1, 16'hFFFF, 6'h2A);
    chk("R1 short absolute", {o1_ax, o1_ay}, {2{16'h002A}});

    preload(8'h10, 24'h800001, 24'h123456);
    preload(8'h11, 24'h7FFFFF, 24'hABCDEF);

    run_op(0, 1, PR_A10, ALU_NONE, 0, 16'h0010, '0);
    expect_load("R7 load A1:A0", 4'b1000);
    chk("R3 load A sign extend", o2_wa, 56'hFF_800001_123456);
    run_op(0, 1, PR_B10, ALU_A, 0, 16'h0011, '0);
    expect_load("R8 B1:B0 with ALU on A is legal", 4'b0100);
    chk("R3 load B", o2_wb, 56'h00_7FFFFF_ABCDEF);
    run_op(0, 1, PR_X, ALU_A, 0, 16'h0010, '0);
    expect_load("R4 load X", 4'b0010);
    chk("R4 load X data", o2_wx, 48'h800001_123456);
    run_op(0, 1, PR_Y, ALU_NONE, 0, 16'h0011, '0);
    expect_load("R4 load Y", 4'b0001);
    chk("R4 load Y data", o2_wy, 48'h7FFFFF_ABCDEF);
    run_op(0, 1, PR_AB, ALU_NONE, 0, 16'h0010, '0);
    expect_load("R6 load AB", 4'b1100);
    chk("R6 AB into A", o2_wa, 56'hFF_800001_000000);
    chk("R6 AB into B", o2_wb, 56'h00_123456_000000);
    run_op(0, 1, PR_BA, ALU_NONE, 0, 16'h0010, '0);
    expect_load("R6 load BA", 4'b1100);
    chk("R6 BA into A", o2_wa, 56'h00_123456_000000);
    chk("R6 BA into B", o2_wb, 56'hFF_800001_000000);

    // R8 destination clashes
    run_op(0, 1, PR_A10, ALU_A, 0, 16'h0010, '0);
    expect_reject("R8 A1:A0 vs ALU A");
    run_op(0, 1, PR_AB, ALU_B, 0, 16'h0010, '0);
    expect_reject("R8 AB vs ALU B");
    run_op(0, 1, PR_BA, ALU_A, 0, 16'h0010, '0);
    expect_reject("R8 BA vs ALU A");
    run_op(0, 1, PR_B10, ALU_B, 0, 16'h0011, '0);
    expect_reject("R8 B1:B0 vs ALU B");

    // R9 duplicate sources on a store
    rf_a = 56'h00_000010_000000; rf_b = 56'h00_000020_000000;
    run_op(1, 1, PR_AB, ALU_A, 0, 16'h0020, '0);
    chk("R9 store with ALU on A", {o1_xwe, o2_done, o2_ill}, 3'b110);
    chk("R9 store data", {o1_xd, o1_yd}, 48'h000010_000020);

    // R10 other illegal forms, store side included
    run_op(1, 0, PR_X, ALU_NONE, 0, 16'h0030, '0);
    expect_reject("R10 pair outside long move");
    run_op(0, 1, 3'd6, ALU_NONE, 0, 16'h0030, '0);
    expect_reject("R10 reserved code");
    run_op(1, 1, PR_Y, ALU_RSV, 0, 16'h0030, '0);
    expect_reject("R10 reserved ALU destination");

    // load then store to the same address on consecutive clocks
    rf_y = 48'h0BADF0_0C0FFE;
    @(negedge clk);
    drive(0, 1, PR_X, ALU_NONE, 0, 16'h0010, '0);
    @(negedge clk);
    chk("R7 overlap read issued", xm_re, 1'b1);
    drive(1, 1, PR_Y, ALU_NONE, 0, 16'h0010, '0);
    @(negedge clk);
    in_valid = 0;
    chk("R7 overlap load gets old data", {rf_we_x, rf_wd_x}, {1'b1, 48'h800001_123456});
    chk("R2 overlap store writes", {xm_we, ym_we, xm_wdata, ym_wdata},
        {2'b11, 24'h0BADF0, 24'h0C0FFE});
    chk("R7 overlap load done", done, 1'b1);
    @(negedge clk);
    chk("R12 overlap store done", {done, rf_we_x}, 2'b10);
    run_op(0, 1, PR_X, ALU_NONE, 0, 16'h0010, '0);
    chk("R2 stored words read back", o2_wx, 48'h0BADF0_0C0FFE);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule